// File: doc/BRIEF.md
# UART DMA Ready Signalling

This block drives the two active-low DMA request lines of a FIFO-buffered UART: a receive-side ready that asks a DMA engine to drain characters, and a transmit-side ready that asks it to supply characters. It does not hold any FIFO storage itself. The surrounding UART provides the FIFO-enable bit, the DMA mode-select bit, the receive occupancy, a trigger-reached flag, a character-timeout flag and the transmit occupancy. When the FIFOs are disabled, a level of 0 or 1 stands for the single holding register.

Two signalling schemes are supported. In single-transfer mode, each ready line follows occupancy directly. The receive line is active while any character waits. The transmit line is active only while nothing is queued. In multi-transfer mode, the receive line is activated by the trigger or timeout flag and then latches active until the receive side is empty. The transmit line stays active while at least one slot is free. Multi-transfer mode can only be selected while the FIFOs are enabled. Both outputs are registered.

Top module: `uart_dma_ready`

## Requirements
- R1: The effective mode is multi-transfer only when `fifo_en`=1 and `dma_sel`=1. In every other combination it is single-transfer, and `dma_sel` has no effect.
- R2: Both outputs are registered. A change on any input appears on the outputs after the next rising clock edge and not before.
- R3: In single-transfer mode, `rx_rdy_n` is 0 when `rx_level` ≥ 1.
- R4: In single-transfer mode, `rx_rdy_n` is 1 when `rx_level` = 0.
- R5: In multi-transfer mode, when `rx_rdy_n` is 1 and either `rx_trig` or `rx_timeout` is 1 with `rx_level` ≥ 1, `rx_rdy_n` becomes 0.
- R6: In multi-transfer mode, once `rx_rdy_n` is 0 it stays 0 while `rx_level` ≥ 1, whatever the flags do. It becomes 1 after `rx_level` reaches 0.
- R7: In multi-transfer mode, while `rx_rdy_n` is 1 and neither flag is set, `rx_rdy_n` stays 1 even with characters present.
- R8: In single-transfer mode, `tx_rdy_n` is 0 exactly when `tx_level` = 0.
- R9: In multi-transfer mode, `tx_rdy_n` is 0 when `tx_level` < FIFO_DEPTH and 1 when `tx_level` = FIFO_DEPTH.
- R10: During and right after reset, `rx_rdy_n` is 1 and `tx_rdy_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_sel | input | 1 | Requests multi-transfer DMA signalling |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Characters held on the receive side |
| rx_trig | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Receive character timeout |
| tx_level | input | $clog2(FIFO_DEPTH+1) | Characters queued on the transmit side |
| rx_rdy_n | output | 1 | Receive DMA ready, active low |
| tx_rdy_n | output | 1 | Transmit DMA ready, active low |

## Verification
Non-FIFO operation is driven with `dma_sel` set and a transmit level of one. Multi-transfer signalling would make `tx_rdy_n` active in that case, and single-transfer signalling keeps it inactive, so this pattern shows whether the mode gate works. In multi-transfer mode, the receive drain sequence lowers the level while both flags are clear, which separates latched behaviour from level-following behaviour. Characters present without a flag, and a flag raised with an empty receive side, show that assertion needs both conditions. Transmit levels of 0, 15 and 16 locate the free-slot boundary, and a same-cycle probe confirms the register stage.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_MULTI  = 1'b1
    } dma_mode_e;

    typedef struct packed {
        logic active;
    } rdy_state_t;
endpackage

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
    import uart_dma_pkg::*;
(
    input  logic      fifo_en,
    input  logic      dma_sel,
    output dma_mode_e mode
);
    always_comb begin
        mode = (fifo_en && dma_sel) ? DMA_MULTI : DMA_SINGLE;
    end
endmodule

// File: rtl/dma_rx_ready.sv
module dma_rx_ready
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_mode_e        mode,
    input  logic [LVL_W-1:0] level,
    input  logic             trig,
    input  logic             timeout,
    output logic             rdy_n
);
    rdy_state_t st_d, st_q;
    logic       has_data;

    always_comb begin
        has_data = (level != '0);
        st_d     = st_q;
        if (mode == DMA_SINGLE) begin
            st_d.active = has_data;
        end else if (st_q.active) begin
            st_d.active = has_data;
        end else begin
            st_d.active = (trig || timeout) && has_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{active: 1'b0};
        else        st_q <= st_d;
    end

    assign rdy_n = ~st_q.active;
endmodule

// File: rtl/dma_tx_ready.sv
module dma_tx_ready
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_mode_e        mode,
    input  logic [LVL_W-1:0] level,
    output logic             rdy_n
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    rdy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode == DMA_SINGLE) st_d.active = (level == '0);
        else                    st_d.active = (level < FULL_LVL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{active: 1'b1};
        else        st_q <= st_d;
    end

    assign rdy_n = ~st_q.active;
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_trig,
    input  logic             rx_timeout,
    input  logic [LVL_W-1:0] tx_level,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n
);
    dma_mode_e mode;

    dma_mode_sel u_mode (
        .fifo_en (fifo_en),
        .dma_sel (dma_sel),
        .mode    (mode)
    );

    dma_rx_ready #(.FIFO_DEPTH(FIFO_DEPTH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .level   (rx_level),
        .trig    (rx_trig),
        .timeout (rx_timeout),
        .rdy_n   (rx_rdy_n)
    );

    dma_tx_ready #(.FIFO_DEPTH(FIFO_DEPTH)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .level (tx_level),
        .rdy_n (tx_rdy_n)
    );
endmodule

// File: rtl/uart_dma_ready_chk.sv
module uart_dma_ready_chk #(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             dma_sel,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_trig,
    input logic             rx_timeout,
    input logic [LVL_W-1:0] tx_level,
    input logic             rx_rdy_n,
    input logic             tx_rdy_n
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
    logic multi;
    assign multi = fifo_en & dma_sel;

    a_r3_single_rx_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi && rx_level != '0) |=> !rx_rdy_n);
    a_r4_single_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi && rx_level == '0) |=> rx_rdy_n);
    a_r5_multi_rx_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && (rx_trig || rx_timeout) && rx_level != '0) |=> !rx_rdy_n);
    a_r6_multi_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && !rx_rdy_n && rx_level != '0) |=> !rx_rdy_n);
    a_r6_multi_rx_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && rx_level == '0) |=> rx_rdy_n);
    a_r7_multi_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (multi && rx_rdy_n && !rx_trig && !rx_timeout) |=> rx_rdy_n);
    a_r8_single_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !multi |=> (tx_rdy_n == ($past(tx_level) != '0)));
    a_r9_multi_tx: assert property (@(posedge clk) disable iff (!rst_n)
        multi |=> (tx_rdy_n == ($past(tx_level) == FULL_LVL)));
    a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && dma_sel && tx_level != '0) |=> tx_rdy_n);
endmodule

bind uart_dma_ready uart_dma_ready_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/tb_uart_dma_ready.sv
module tb_uart_dma_ready;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0, dma_sel = 1'b0, rx_trig = 1'b0, rx_timeout = 1'b0;
    logic [LW-1:0] rx_level = '0, tx_level = '0;
    logic rx_rdy_n, tx_rdy_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic  rx;
        logic  tx;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    uart_dma_ready #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_sel(dma_sel),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
        .tx_level(tx_level), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic fe, input logic ds, input int rxl, input logic tg,
                         input logic to, input int txl, input logic erx, input logic etx,
                         input string tag);
        exp_t e;
        @(negedge clk);
        fifo_en = fe; dma_sel = ds; rx_level = LW'(rxl);
        rx_trig = tg; rx_timeout = to; tx_level = LW'(txl);
        e.rx = erx; e.tx = etx; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: outputs registered at posedge, sampled 5 ns later
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(rx_rdy_n, e.rx, e.tag, "rx_rdy_n");
            check(tx_rdy_n, e.tx, e.tag, "tx_rdy_n");
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_rdy_n, 1'b1, "R10", "rx_rdy_n in reset");
        check(tx_rdy_n, 1'b0, "R10", "tx_rdy_n in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_rdy_n, 1'b1, "R10", "rx_rdy_n after reset");
        check(tx_rdy_n, 1'b0, "R10", "tx_rdy_n after reset");

        // FIFOs off, mode select set: single-transfer holds
        apply(0, 1, 0, 0, 0, 0, 1, 0, "R4");
        apply(0, 1, 1, 0, 0, 1, 0, 1, "R3");
        apply(0, 1, 0, 0, 0, 1, 1, 1, "R1");
        apply(0, 1, 0, 1, 1, 0, 1, 0, "R8");
        // FIFO single-transfer
        apply(1, 0, 5, 1, 0, 3, 0, 1, "R3");
        apply(1, 0, 0, 0, 0, 16, 1, 1, "R4");
        // FIFO multi-transfer fill and drain
        apply(1, 1, 3, 0, 0, 0, 1, 0, "R7");
        apply(1, 1, 8, 1, 0, 15, 0, 0, "R5");
        apply(1, 1, 7, 0, 0, 16, 0, 1, "R6");
        apply(1, 1, 1, 0, 0, 16, 0, 1, "R6");
        apply(1, 1, 0, 0, 0, 10, 1, 0, "R6");
        apply(1, 1, 2, 0, 0, 10, 1, 0, "R7");
        apply(1, 1, 2, 0, 1, 10, 0, 0, "R5");
        apply(1, 1, 0, 0, 0, 0, 1, 0, "R9");
        apply(1, 1, 0, 1, 0, 16, 1, 1, "R5");
        repeat (3) @(negedge clk);

        // R2: register stage probe
        @(negedge clk);
        fifo_en = 1'b0; dma_sel = 1'b0; rx_level = LW'(4); tx_level = LW'(2);
        #1;
        check(rx_rdy_n, 1'b1, "R2", "rx_rdy_n before edge");
        @(posedge clk);
        #5;
        check(rx_rdy_n, 1'b0, "R2", "rx_rdy_n after edge");
        check(tx_rdy_n, 1'b1, "R2", "tx_rdy_n after edge");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule